// File: doc/BRIEF.md
# Burst Receive DMA Memory Channel

This block is the slave side of an external DMA transfer in receive direction. Once software has loaded a start address and an end address and has started the channel, the block raises a DMA request towards an external controller. That controller then pushes bytes one after another with a write strobe while it holds the acknowledge line low. Each byte is latched, offered to internal memory through a request/acknowledge handshake and committed at the current address. The address then advances.

Only burst receive operation exists. The request stays asserted across many bytes. A burst finishes in one of two ways. In the first, the byte written at the programmed end address is acknowledged, which raises a sticky end interrupt. In the second, a rising edge on the terminal-count input withdraws the request, and the channel then goes idle quietly once any byte already latched has been committed.

The strobe, acknowledge and terminal-count inputs are asynchronous. Each passes through a two-flop synchroniser, and edges are found on the synchronised copies.

Top module: `dma_rx_channel`

## Requirements
- R1: After reset, ext_dreq, mem_req, irq, overrun and busy are all 0.
- R2: A one-cycle pulse on en_set while idle, with cfg_dir equal to 2'b01 and cfg_burst equal to 1, sets busy and ext_dreq on the next clock edge. With any other cfg_dir or with cfg_burst at 0, the pulse leaves both at 0.
- R3: When busy, a falling edge of ext_wr_n seen while ext_dack_n is low latches ext_dq. mem_req then rises, with mem_data holding the byte and mem_addr holding the current address. ext_a0 and ext_cs have no effect on this. A strobe seen while ext_dack_n is high latches nothing and leaves mem_req at 0.
- R4: A cycle with both mem_req and mem_ack high commits the byte. mem_addr then increments by one, mem_req falls, and ext_dreq stays at 1 while the burst continues.
- R5: While mem_req is high and mem_ack is low, mem_req, mem_addr and mem_data hold their values.
- R6: When the byte at the address equal to the end address is acknowledged, the channel sets irq and clears busy and ext_dreq on that clock edge. This also happens when a terminal-count edge is acted on in the same cycle.
- R7: ext_dreq falls on the third rising clock edge after ext_tc rises, with no irq. If no byte is pending, busy falls on that same edge. Otherwise the pending byte is still committed, and busy falls when it is acknowledged.
- R8: A new qualified strobe that arrives while a byte waits for mem_ack sets overrun. mem_data keeps the waiting byte.
- R9: A pulse on sts_clr clears irq and overrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dir | input | 2 | Direction field, 2'b01 selects receive |
| cfg_burst | input | 1 | 1 selects burst operation |
| en_set | input | 1 | Start pulse (enable bit write of 1) |
| cfg_ld | input | 1 | Loads start and end address while idle |
| cfg_start | input | AW | Start value of the address counter |
| cfg_end | input | AW | End address |
| sts_clr | input | 1 | Clears irq and overrun |
| ext_wr_n | input | 1 | External write strobe, active low |
| ext_dack_n | input | 1 | DMA acknowledge, active low |
| ext_tc | input | 1 | Terminal count, acted on at its rising edge |
| ext_cs | input | 1 | Chip select, unused during DMA cycles |
| ext_a0 | input | 1 | Address bit, unused during DMA cycles |
| ext_dq | input | 8 | External data bus |
| ext_dreq | output | 1 | DMA request to the external controller |
| mem_req | output | 1 | Internal memory write request |
| mem_ack | input | 1 | Internal memory write acknowledge |
| mem_addr | output | AW | Address counter |
| mem_data | output | 8 | Receive buffer |
| busy | output | 1 | Enable bit, cleared when the operation ends |
| irq | output | 1 | Sticky end-of-operation interrupt |
| overrun | output | 1 | Sticky overrun flag |

## Verification
The terminal-count edge and the acknowledge of the byte at the end address can meet in the same clock cycle. The bench raises ext_tc on the falling edge at which it first sees mem_req. It then raises mem_ack two falling edges later, so that the synchronised edge and the acknowledge both reach the third rising edge. The result is judged correct only if irq is set and busy and ext_dreq are cleared, because the end-address completion must not be lost to the quieter terminal-count stop.

// File: rtl/dma_rx_pkg.sv
package dma_rx_pkg;
    localparam logic [1:0] DIR_RECEIVE = 2'b01;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_ARMED    = 2'd1,
        ST_LATCH    = 2'd2,
        ST_WAIT_ACK = 2'd3
    } rx_state_e;
endpackage

// File: rtl/dma_rx_sync.sv
module dma_rx_sync #(
    parameter int               W   = 3,
    parameter logic [W-1:0]     RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic stage1_q;
        logic stage2_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage1_q <= RST[i];
                stage2_q <= RST[i];
            end else begin
                stage1_q <= async_in[i];
                stage2_q <= stage1_q;
            end
        end
        assign sync_out[i] = stage2_q;
    end
endmodule

// File: rtl/dma_rx_edge.sv
module dma_rx_edge #(
    parameter int           W   = 3,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] level,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= RST;
        else        prev_q <= level;
    end

    assign rise = level & ~prev_q;
    assign fall = ~level & prev_q;
endmodule

// File: rtl/dma_rx_channel.sv
module dma_rx_channel
    import dma_rx_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_dir,
    input  logic          cfg_burst,
    input  logic          en_set,
    input  logic          cfg_ld,
    input  logic [AW-1:0] cfg_start,
    input  logic [AW-1:0] cfg_end,
    input  logic          sts_clr,
    input  logic          ext_wr_n,
    input  logic          ext_dack_n,
    input  logic          ext_tc,
    input  logic          ext_cs,
    input  logic          ext_a0,
    input  logic [7:0]    ext_dq,
    output logic          ext_dreq,
    output logic          mem_req,
    input  logic          mem_ack,
    output logic [AW-1:0] mem_addr,
    output logic [7:0]    mem_data,
    output logic          busy,
    output logic          irq,
    output logic          overrun
);
    localparam int         NSIG    = 3;
    localparam int         IDX_WR  = 0;
    localparam int         IDX_ACK = 1;
    localparam int         IDX_TC  = 2;
    localparam logic [NSIG-1:0] IDLE_LEVELS = 3'b011;

    typedef struct packed {
        rx_state_e     st;
        logic          en;
        logic          dreq;
        logic          tc_seen;
        logic          irq;
        logic          ovr;
        logic [7:0]    rxbuf;
        logic [AW-1:0] addr;
        logic [AW-1:0] end_addr;
    } chan_t;

    chan_t r_q, r_d;

    logic [NSIG-1:0] raw_in, sync_lv, lv_rise, lv_fall;
    logic            unused_pins;

    assign raw_in      = {ext_tc, ext_dack_n, ext_wr_n};
    assign unused_pins = ext_cs ^ ext_a0;

    dma_rx_sync #(.W(NSIG), .RST(IDLE_LEVELS)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (raw_in),
        .sync_out (sync_lv)
    );

    dma_rx_edge #(.W(NSIG), .RST(IDLE_LEVELS)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (sync_lv),
        .rise  (lv_rise),
        .fall  (lv_fall)
    );

    logic wr_hit, tc_rise, at_end;
    assign wr_hit  = lv_fall[IDX_WR] & ~sync_lv[IDX_ACK];
    assign tc_rise = lv_rise[IDX_TC];
    assign at_end  = (r_q.addr == r_q.end_addr);

    always_comb begin
        r_d = r_q;
        if (sts_clr) begin
            r_d.irq = 1'b0;
            r_d.ovr = 1'b0;
        end
        case (r_q.st)
            ST_IDLE: begin
                if (cfg_ld) begin
                    r_d.addr     = cfg_start;
                    r_d.end_addr = cfg_end;
                end
                if (en_set && cfg_dir == DIR_RECEIVE && cfg_burst) begin
                    r_d.en      = 1'b1;
                    r_d.dreq    = 1'b1;
                    r_d.tc_seen = 1'b0;
                    r_d.st      = ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (tc_rise) begin
                    r_d.en   = 1'b0;
                    r_d.dreq = 1'b0;
                    r_d.st   = ST_IDLE;
                end else if (wr_hit) begin
                    r_d.rxbuf = ext_dq;
                    r_d.st    = ST_LATCH;
                end
            end
            ST_LATCH: begin
                r_d.st = ST_WAIT_ACK;
                if (wr_hit)  r_d.ovr = 1'b1;
                if (tc_rise) begin
                    r_d.tc_seen = 1'b1;
                    r_d.dreq    = 1'b0;
                end
            end
            ST_WAIT_ACK: begin
                if (wr_hit)  r_d.ovr = 1'b1;
                if (tc_rise) begin
                    r_d.tc_seen = 1'b1;
                    r_d.dreq    = 1'b0;
                end
                if (mem_ack) begin
                    r_d.addr = r_q.addr + 1'b1;
                    if (at_end) begin
                        r_d.irq  = 1'b1;
                        r_d.en   = 1'b0;
                        r_d.dreq = 1'b0;
                        r_d.st   = ST_IDLE;
                    end else if (r_q.tc_seen || tc_rise) begin
                        r_d.en   = 1'b0;
                        r_d.dreq = 1'b0;
                        r_d.st   = ST_IDLE;
                    end else begin
                        r_d.st = ST_ARMED;
                    end
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, en: 1'b0, dreq: 1'b0, tc_seen: 1'b0,
                     irq: 1'b0, ovr: 1'b0, rxbuf: '0, addr: '0, end_addr: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ext_dreq = r_q.dreq;
    assign mem_req  = (r_q.st == ST_WAIT_ACK);
    assign mem_addr = r_q.addr;
    assign mem_data = r_q.rxbuf;
    assign busy     = r_q.en;
    assign irq      = r_q.irq;
    assign overrun  = r_q.ovr;
endmodule

// File: rtl/dma_rx_channel_chk.sv
module dma_rx_channel_chk #(
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          ext_dreq,
    input logic          mem_req,
    input logic          mem_ack,
    input logic [AW-1:0] mem_addr,
    input logic [7:0]    mem_data,
    input logic          busy,
    input logic          irq,
    input logic          overrun
);
    a_r2_request_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        ext_dreq |-> busy);

    a_r5_pending_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_data)));

    a_r4_ack_advances: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack) |=> (mem_addr == $past(mem_addr) + 1'b1) && !mem_req);

    a_r6_irq_ends_operation: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (!busy && !ext_dreq));

    a_r8_overrun_keeps_byte: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(overrun) |-> $stable(mem_data));
endmodule

bind dma_rx_channel dma_rx_channel_chk #(.AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ext_dreq (ext_dreq),
    .mem_req  (mem_req),
    .mem_ack  (mem_ack),
    .mem_addr (mem_addr),
    .mem_data (mem_data),
    .busy     (busy),
    .irq      (irq),
    .overrun  (overrun)
);

// File: tb/tb_dma_rx_channel.sv
module tb_dma_rx_channel;
    localparam int CLK_PERIOD = 10;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    cfg_dir = 2'b00;
    logic          cfg_burst = 1'b0;
    logic          en_set = 1'b0;
    logic          cfg_ld = 1'b0;
    logic [AW-1:0] cfg_start = '0;
    logic [AW-1:0] cfg_end = '0;
    logic          sts_clr = 1'b0;
    logic          ext_wr_n = 1'b1;
    logic          ext_dack_n = 1'b1;
    logic          ext_tc = 1'b0;
    logic          ext_cs = 1'b1;
    logic          ext_a0 = 1'b0;
    logic [7:0]    ext_dq = '0;
    logic          ext_dreq, mem_req, busy, irq, overrun;
    logic          mem_ack = 1'b0;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_data;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dma_rx_channel #(.AW(AW)) dut (.*);

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic start(logic [AW-1:0] s, logic [AW-1:0] e);
        @(negedge clk);
        cfg_ld = 1'b1; cfg_start = s; cfg_end = e;
        @(negedge clk);
        cfg_ld = 1'b0; cfg_dir = 2'b01; cfg_burst = 1'b1; en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
    endtask

    task automatic ext_write(logic [7:0] d, logic a0, logic cs);
        ext_dq = d; ext_a0 = a0; ext_cs = cs; ext_wr_n = 1'b0;
        repeat (4) @(negedge clk);
        ext_wr_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic wait_req();
        for (int i = 0; i < 30 && !mem_req; i++) @(negedge clk);
    endtask

    task automatic give_ack();
        mem_ack = 1'b1;
        @(negedge clk);
        mem_ack = 1'b0;
    endtask

    task automatic clear_status();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 dreq", ext_dreq, 0);
        check("R1 mem_req", mem_req, 0);
        check("R1 irq", irq, 0);
        check("R1 overrun", overrun, 0);
        check("R1 busy", busy, 0);
    endtask

    task automatic t_bad_start();
        @(negedge clk);
        cfg_dir = 2'b10; cfg_burst = 1'b1; en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        check("R2 wrong dir busy", busy, 0);
        check("R2 wrong dir dreq", ext_dreq, 0);
        cfg_dir = 2'b01; cfg_burst = 1'b0; en_set = 1'b1;
        @(negedge clk);
        en_set = 1'b0;
        check("R2 no burst busy", busy, 0);
    endtask

    task automatic t_burst_to_end();
        start(16'h0100, 16'h0102);
        check("R2 start busy", busy, 1);
        check("R2 start dreq", ext_dreq, 1);
        ext_dack_n = 1'b0;
        ext_write(8'hA5, 1'b0, 1'b1);
        wait_req();
        check("R3 req", mem_req, 1);
        check("R3 addr0", mem_addr, 16'h0100);
        check("R3 data0", mem_data, 8'hA5);
        repeat (3) @(negedge clk);
        check("R5 held req", mem_req, 1);
        check("R5 held data", mem_data, 8'hA5);
        give_ack();
        check("R4 req drop", mem_req, 0);
        check("R4 addr inc", mem_addr, 16'h0101);
        check("R4 dreq kept", ext_dreq, 1);
        ext_write(8'h3C, 1'b1, 1'b0);
        wait_req();
        check("R3 a0/cs ignored data", mem_data, 8'h3C);
        check("R3 addr1", mem_addr, 16'h0101);
        give_ack();
        ext_write(8'h7E, 1'b0, 1'b1);
        wait_req();
        check("R3 addr2", mem_addr, 16'h0102);
        check("R6 no irq before ack", irq, 0);
        give_ack();
        check("R6 irq", irq, 1);
        check("R6 busy clr", busy, 0);
        check("R6 dreq clr", ext_dreq, 0);
        clear_status();
        check("R9 irq clr", irq, 0);
        ext_dack_n = 1'b1;
    endtask

    task automatic t_no_dack_and_tc();
        start(16'h0010, 16'h001F);
        ext_dack_n = 1'b1;
        ext_write(8'h42, 1'b0, 1'b1);
        repeat (4) @(negedge clk);
        check("R3 no dack ignored", mem_req, 0);
        ext_tc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R7 dreq before 3rd edge", ext_dreq, 1);
        @(negedge clk);
        check("R7 dreq at 3rd edge", ext_dreq, 0);
        check("R7 idle busy", busy, 0);
        check("R7 no irq", irq, 0);
        ext_tc = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_tc_pending();
        start(16'h0200, 16'h020F);
        ext_dack_n = 1'b0;
        ext_write(8'h11, 1'b0, 1'b1);
        wait_req();
        ext_tc = 1'b1;
        repeat (4) @(negedge clk);
        check("R7 pending dreq", ext_dreq, 0);
        check("R7 pending busy", busy, 1);
        give_ack();
        check("R7 after commit busy", busy, 0);
        check("R7 after commit irq", irq, 0);
        check("R7 after commit addr", mem_addr, 16'h0201);
        ext_tc = 1'b0;
        ext_dack_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_overrun();
        start(16'h0300, 16'h0301);
        ext_dack_n = 1'b0;
        ext_write(8'h55, 1'b0, 1'b1);
        wait_req();
        ext_write(8'h66, 1'b0, 1'b1);
        check("R8 overrun", overrun, 1);
        check("R8 byte kept", mem_data, 8'h55);
        check("R8 still req", mem_req, 1);
        give_ack();
        ext_write(8'h77, 1'b0, 1'b1);
        wait_req();
        check("R8 next byte", mem_data, 8'h77);
        give_ack();
        check("R6 irq end2", irq, 1);
        clear_status();
        check("R9 overrun clr", overrun, 0);
        check("R9 irq clr2", irq, 0);
        ext_dack_n = 1'b1;
    endtask

    task automatic t_coincide();
        start(16'h0400, 16'h0400);
        ext_dack_n = 1'b0;
        ext_write(8'h99, 1'b0, 1'b1);
        wait_req();
        ext_tc = 1'b1;
        @(negedge clk);
        @(negedge clk);
        give_ack();
        check("R6 coincide irq", irq, 1);
        check("R6 coincide busy", busy, 0);
        check("R6 coincide dreq", ext_dreq, 0);
        ext_tc = 1'b0;
        ext_dack_n = 1'b1;
        clear_status();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        t_bad_start();
        t_burst_to_end();
        t_no_dack_and_tc();
        t_tc_pending();
        t_overrun();
        t_coincide();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule